// File: doc/BRIEF.md
# In-Order Pipeline Hazard Controller

This block decides, cycle by cycle, whether the fetch and decode stages of a single-issue, five-stage in-order pipeline may advance. It has no operand forwarding and no branch prediction. It keeps a ready bit for every architectural register. Decode is held while the op there reads a register that an older op has not yet retired. Fetch is frozen from the moment a control-flow op sits in decode until that op resolves in the memory stage. Both stages are held while a multi-cycle op occupies execute.

When decode holds on a register dependency, the block asks the pipeline to send a bubble into execute. When the branch resolves, it gives a PC-load enable. It also keeps three statistics counters: retired ops, data-hazard cycles and control-hazard cycles. A watchdog ends the run when no op has left decode for a long stretch. The datapath, the caches and instruction decoding belong to the surrounding pipeline.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset every register is ready, all counters read zero, `timeout_o` is low, and a decode op whose sources are valid does not stall.
- R2: A decode op with a valid source whose register is not ready raises `dec_stall_o` and `fe_stall_o` in that same cycle. A source whose valid flag is low is ignored.
- R3: While decode holds on a register dependency and execute is not busy, `bubble_o` is high. During a multi-cycle execute stall it is low.
- R4: A writeback with a valid destination makes that register ready for a decode read in the same cycle. A writeback whose destination flag is low releases nothing.
- R5: An op with a valid destination clears that register's ready bit when it leaves decode. A writeback sets the bit again. If both happen for one register in the same cycle, the register ends not ready.
- R6: When an op enters execute with latency L, fetch and decode stall for L-1 cycles, starting in that cycle. A latency of 0 or 1 causes no stall.
- R7: A control-flow op in decode stalls fetch. Fetch stays stalled until the cycle that carries the memory-stage resolve pulse, and it is free in the cycle after that.
- R8: `pc_redirect_o` is high in the resolve-pulse cycle of a pending branch. A resolve pulse with no branch pending is ignored.
- R9: The data-hazard counter rises by one for each cycle in which a valid decode op waits on a register, whether one source or both sources are not ready. The count is visible one cycle later.
- R10: The control-hazard counter rises by one for each cycle in which a valid control-flow op sits in decode.
- R11: The retired counter rises by one for each cycle with a valid writeback.
- R12: After 1000 consecutive clock edges with no op leaving decode, `timeout_o` rises and stays high. From then on both stall outputs are held high and all counters are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode stage holds an op |
| dec_src_a_i | input | 5 | First source register index |
| dec_src_a_vld_i | input | 1 | First source is used |
| dec_src_b_i | input | 5 | Second source register index |
| dec_src_b_vld_i | input | 1 | Second source is used |
| dec_dst_i | input | 5 | Destination register index |
| dec_dst_vld_i | input | 1 | Op writes a destination |
| dec_ctrl_i | input | 1 | Decode op is control flow |
| ex_new_i | input | 1 | An op is in its first execute cycle |
| ex_lat_i | input | 4 | Latency of that op in cycles |
| mem_resolve_i | input | 1 | Branch resolved in the memory stage |
| wb_valid_i | input | 1 | An op retires this cycle |
| wb_dst_i | input | 5 | Retiring op's destination index |
| wb_dst_vld_i | input | 1 | Retiring op writes a destination |
| fe_stall_o | output | 1 | Hold the fetch latch |
| dec_stall_o | output | 1 | Hold the decode latch |
| bubble_o | output | 1 | Send an invalid op into execute |
| pc_redirect_o | output | 1 | Load the resolved target into the PC |
| retired_cnt_o | output | 32 | Retired op count |
| data_haz_cnt_o | output | 32 | Data-hazard cycle count |
| ctrl_haz_cnt_o | output | 32 | Control-hazard cycle count |
| timeout_o | output | 1 | Watchdog expired |

## Verification
The bench sweeps all 32 registers. For each one it issues a producer, then a consumer on one source or on both. The writeback that releases the consumer comes in the same cycle as the consumer's read. A design that treats a same-cycle writeback as too late stalls one cycle too many. A design that counts each source stalled separately doubles the data-hazard count on the two-source cases.

A producer issue that coincides with a writeback to the same register must leave that register busy. If the set wins, a dependent op is released early. Execute latencies from 0 to 6 catch an off-by-one in the stall window. The branch cases check that fetch reopens exactly one cycle after the resolve pulse, and that a stray resolve pulse causes no redirect.

The watchdog is probed one edge before and one edge after its limit. After it fires, the bench checks that the counters no longer move.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned HZ_NUM_REGS  = 32;
  localparam int unsigned HZ_NUM_SRC   = 2;
  localparam int unsigned HZ_WDOG_IDLE = 1000;

  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_DATA,
    CAUSE_EXEC,
    CAUSE_HALT
  } dec_cause_e;
endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_SRC  = 2,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] rd_idx_i,
  input  logic [NUM_SRC-1:0]            rd_vld_i,
  input  logic                          set_en_i,
  input  logic [IDX_W-1:0]              set_idx_i,
  input  logic                          clr_en_i,
  input  logic [IDX_W-1:0]              clr_idx_i,
  output logic                          src_wait_o
);
  logic [NUM_REGS-1:0] rdy_q;
  logic [NUM_SRC-1:0]  wait_s;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rdy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   rdy_q[g] <= 1'b1;
      else if (clr_en_i && clr_idx_i == IDX_W'(g))   rdy_q[g] <= 1'b0;  // issue beats retire
      else if (set_en_i && set_idx_i == IDX_W'(g))   rdy_q[g] <= 1'b1;
    end
  end

  // writeback in this cycle counts as ready for a read in this cycle
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic byp;
    assign byp       = set_en_i && (set_idx_i == rd_idx_i[s]);
    assign wait_s[s] = rd_vld_i[s] && !(rdy_q[rd_idx_i[s]] || byp);
  end

  assign src_wait_o = |wait_s;

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && set_en_i && clr_idx_i == set_idx_i) |=> !rdy_q[$past(clr_idx_i)]);

  p_set_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !(clr_en_i && clr_idx_i == set_idx_i)) |=> rdy_q[$past(set_idx_i)]);
endmodule

// File: rtl/hz_exec_timer.sv
module hz_exec_timer #(
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ex_new_i,
  input  logic [LAT_W-1:0] ex_lat_i,
  output logic             busy_o
);
  logic [LAT_W-1:0] cnt_q;
  logic             long_op;

  assign long_op = ex_lat_i > LAT_W'(1);
  assign busy_o  = (ex_new_i && long_op) || (cnt_q != '0);

  // cnt_q: stall cycles still owed after the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (ex_new_i)        cnt_q <= long_op ? ex_lat_i - LAT_W'(2) : '0;
    else if (cnt_q != '0)     cnt_q <= cnt_q - LAT_W'(1);
  end

  p_countdown_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !ex_new_i) |=> (cnt_q == $past(cnt_q) - LAT_W'(1)));
endmodule

// File: rtl/hz_branch_fence.sv
module hz_branch_fence (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_in_dec_i,
  input  logic ctrl_fire_i,
  input  logic resolve_i,
  output logic fe_block_o,
  output logic pend_o,
  output logic redirect_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (ctrl_fire_i) pend_q <= 1'b1;
    else if (resolve_i)   pend_q <= 1'b0;
  end

  assign fe_block_o = ctrl_in_dec_i || pend_q;
  assign redirect_o = resolve_i && pend_q;
  assign pend_o     = pend_q;

  p_redirect_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !ctrl_fire_i) |=> !pend_q);
endmodule

// File: rtl/hz_stats.sv
module hz_stats #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WDOG_LIMIT = 1000,
  localparam int unsigned IDLE_W    = $clog2(WDOG_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_data_i,
  input  logic             inc_ctrl_i,
  input  logic             inc_ret_i,
  input  logic             activity_i,
  output logic [CNT_W-1:0] data_cnt_o,
  output logic [CNT_W-1:0] ctrl_cnt_o,
  output logic [CNT_W-1:0] ret_cnt_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0]  data_q, ctrl_q, ret_q;
  logic [IDLE_W-1:0] idle_q;
  logic              tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
      ret_q  <= '0;
    end else if (!tmo_q) begin
      if (inc_data_i) data_q <= data_q + CNT_W'(1);
      if (inc_ctrl_i) ctrl_q <= ctrl_q + CNT_W'(1);
      if (inc_ret_i)  ret_q  <= ret_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      tmo_q  <= 1'b0;
    end else if (!tmo_q) begin
      if (activity_i)                             idle_q <= '0;
      else if (idle_q == IDLE_W'(WDOG_LIMIT - 1)) tmo_q  <= 1'b1;
      else                                        idle_q <= idle_q + IDLE_W'(1);
    end
  end

  assign data_cnt_o = data_q;
  assign ctrl_cnt_o = ctrl_q;
  assign ret_cnt_o  = ret_q;
  assign timeout_o  = tmo_q;

  p_data_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (data_q - $past(data_q)) <= CNT_W'(1));

  p_timeout_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q |=> (tmo_q && $stable(ret_q) && $stable(data_q) && $stable(ctrl_q)));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned NUM_REGS   = HZ_NUM_REGS,
  parameter int unsigned LAT_W      = 4,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned WDOG_LIMIT = HZ_WDOG_IDLE,
  localparam int unsigned IDX_W     = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [IDX_W-1:0] dec_src_a_i,
  input  logic             dec_src_a_vld_i,
  input  logic [IDX_W-1:0] dec_src_b_i,
  input  logic             dec_src_b_vld_i,
  input  logic [IDX_W-1:0] dec_dst_i,
  input  logic             dec_dst_vld_i,
  input  logic             dec_ctrl_i,
  input  logic             ex_new_i,
  input  logic [LAT_W-1:0] ex_lat_i,
  input  logic             mem_resolve_i,
  input  logic             wb_valid_i,
  input  logic [IDX_W-1:0] wb_dst_i,
  input  logic             wb_dst_vld_i,
  output logic             fe_stall_o,
  output logic             dec_stall_o,
  output logic             bubble_o,
  output logic             pc_redirect_o,
  output logic [CNT_W-1:0] retired_cnt_o,
  output logic [CNT_W-1:0] data_haz_cnt_o,
  output logic [CNT_W-1:0] ctrl_haz_cnt_o,
  output logic             timeout_o
);
  logic [HZ_NUM_SRC-1:0][IDX_W-1:0] rd_idx;
  logic [HZ_NUM_SRC-1:0]            rd_vld;
  logic       src_wait, ex_busy, fe_block, br_pend, tmo;
  logic       wb_set, dec_fire;
  dec_cause_e cause;

  assign rd_idx = {dec_src_b_i, dec_src_a_i};
  assign rd_vld = {dec_src_b_vld_i, dec_src_a_vld_i};
  assign wb_set = wb_valid_i && wb_dst_vld_i;

  always_comb begin
    if (tmo)                           cause = CAUSE_HALT;
    else if (ex_busy)                  cause = CAUSE_EXEC;
    else if (dec_valid_i && src_wait)  cause = CAUSE_DATA;
    else                               cause = CAUSE_NONE;
  end

  assign dec_stall_o = (cause != CAUSE_NONE);
  assign dec_fire    = dec_valid_i && !dec_stall_o;
  assign bubble_o    = (cause == CAUSE_DATA);
  assign fe_stall_o  = dec_stall_o || fe_block;

  hz_scoreboard #(.NUM_REGS(NUM_REGS), .NUM_SRC(HZ_NUM_SRC)) u_sb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_vld_i   (rd_vld),
    .set_en_i   (wb_set),
    .set_idx_i  (wb_dst_i),
    .clr_en_i   (dec_fire && dec_dst_vld_i),
    .clr_idx_i  (dec_dst_i),
    .src_wait_o (src_wait)
  );

  hz_exec_timer #(.LAT_W(LAT_W)) u_ex (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ex_new_i (ex_new_i),
    .ex_lat_i (ex_lat_i),
    .busy_o   (ex_busy)
  );

  hz_branch_fence u_br (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctrl_in_dec_i (dec_valid_i && dec_ctrl_i),
    .ctrl_fire_i   (dec_fire && dec_ctrl_i),
    .resolve_i     (mem_resolve_i),
    .fe_block_o    (fe_block),
    .pend_o        (br_pend),
    .redirect_o    (pc_redirect_o)
  );

  hz_stats #(.CNT_W(CNT_W), .WDOG_LIMIT(WDOG_LIMIT)) u_st (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_data_i (dec_valid_i && src_wait),
    .inc_ctrl_i (dec_valid_i && dec_ctrl_i),
    .inc_ret_i  (wb_valid_i),
    .activity_i (dec_fire),
    .data_cnt_o (data_haz_cnt_o),
    .ctrl_cnt_o (ctrl_haz_cnt_o),
    .ret_cnt_o  (retired_cnt_o),
    .timeout_o  (tmo)
  );

  assign timeout_o = tmo;

  p_dec_holds_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_stall_o |-> fe_stall_o);

  p_fe_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_pend |-> fe_stall_o);

  p_no_bubble_in_exec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_busy |-> !bubble_o);
endmodule

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic dec_valid, sa_vld, sb_vld, dst_vld, ctrl, ex_new, resolve, wb_valid, wb_dst_vld;
  logic [4:0] sa, sb, dst, wb_dst;
  logic [3:0] ex_lat;
  logic fe_stall, dec_stall, bubble, redirect, timeout;
  logic [31:0] ret_cnt, dh_cnt, ch_cnt;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_dh = 0, exp_ch = 0, exp_ret = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dec_valid_i(dec_valid), .dec_src_a_i(sa), .dec_src_a_vld_i(sa_vld),
    .dec_src_b_i(sb), .dec_src_b_vld_i(sb_vld), .dec_dst_i(dst), .dec_dst_vld_i(dst_vld),
    .dec_ctrl_i(ctrl), .ex_new_i(ex_new), .ex_lat_i(ex_lat), .mem_resolve_i(resolve),
    .wb_valid_i(wb_valid), .wb_dst_i(wb_dst), .wb_dst_vld_i(wb_dst_vld),
    .fe_stall_o(fe_stall), .dec_stall_o(dec_stall), .bubble_o(bubble),
    .pc_redirect_o(redirect), .retired_cnt_o(ret_cnt), .data_haz_cnt_o(dh_cnt),
    .ctrl_haz_cnt_o(ch_cnt), .timeout_o(timeout)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    dec_valid = 0; sa = 0; sa_vld = 0; sb = 0; sb_vld = 0; dst = 0; dst_vld = 0;
    ctrl = 0; ex_new = 0; ex_lat = 0; resolve = 0; wb_valid = 0; wb_dst = 0; wb_dst_vld = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_in();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        finish_run();
      end
    end
  end

  initial begin : stim
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    #1;
    chk("R1 dec_stall", dec_stall, 0);
    chk("R1 fe_stall", fe_stall, 0);
    chk("R1 retired", ret_cnt, 0);
    chk("R1 data_haz", dh_cnt, 0);
    chk("R1 ctrl_haz", ch_cnt, 0);
    chk("R1 timeout", timeout, 0);
    for (int r = 0; r < 32; r++) begin
      dec_valid = 1; sa = 5'(r); sa_vld = 1; sb = 5'(31 - r); sb_vld = 1;
      #1 chk("R1 all ready", dec_stall, 0);
    end
    idle_in();

    // R2 R3 R4 R5 R9 R11: full register sweep
    for (int r = 0; r < 32; r++) begin
      dec_valid = 1; dst = 5'(r); dst_vld = 1;
      #1 chk("R5 producer issues", dec_stall, 0);
      tick();
      dec_valid = 1;
      sa = 5'(r); sb = (r % 2 == 1) ? 5'(r) : 5'((r + 1) % 32);
      sa_vld = 0; sb_vld = 0;
      #1 chk("R2 invalid source ignored", dec_stall, 0);
      sa_vld = 1; sb_vld = (r % 2 == 1);
      #1;
      chk("R2 dec_stall on busy source", dec_stall, 1);
      chk("R2 fe_stall on busy source", fe_stall, 1);
      chk("R3 bubble on data stall", bubble, 1);
      tick(); exp_dh++;
      dec_valid = 1; sa = 5'(r); sa_vld = 1;
      if (r % 2 == 1) begin sb = 5'(r); sb_vld = 1; end
      wb_valid = 1; wb_dst = 5'(r); wb_dst_vld = 1;
      #1 chk("R4 same-cycle writeback release", dec_stall, 0);
      tick(); exp_ret++;
    end
    #1;
    chk("R9 data hazard count once per cycle", dh_cnt, 32'(exp_dh));
    chk("R11 retired count", ret_cnt, 32'(exp_ret));

    // R5: issue and retire same register in one cycle -> busy
    dec_valid = 1; dst = 7; dst_vld = 1;
    wb_valid = 1; wb_dst = 7; wb_dst_vld = 1;
    tick(); exp_ret++;
    dec_valid = 1; sa = 7; sa_vld = 1;
    #1 chk("R5 clear wins over set", dec_stall, 1);
    tick(); exp_dh++;
    dec_valid = 1; sa = 7; sa_vld = 1; wb_valid = 1; wb_dst = 7; wb_dst_vld = 1;
    #1 chk("R5 released by later writeback", dec_stall, 0);
    tick(); exp_ret++;

    // R4: writeback without destination releases nothing
    dec_valid = 1; dst = 8; dst_vld = 1;
    tick();
    dec_valid = 1; sa = 8; sa_vld = 1; wb_valid = 1; wb_dst = 8; wb_dst_vld = 0;
    #1 chk("R4 writeback flag low", dec_stall, 1);
    tick(); exp_ret++; exp_dh++;
    dec_valid = 1; sa = 8; sa_vld = 1; wb_valid = 1; wb_dst = 8; wb_dst_vld = 1;
    #1 chk("R4 writeback flag high", dec_stall, 0);
    tick(); exp_ret++;
    #1;
    chk("R9 data hazard count", dh_cnt, 32'(exp_dh));
    chk("R11 retired count", ret_cnt, 32'(exp_ret));

    // R6 R3: execute latency sweep
    for (int L = 0; L <= 6; L++) begin
      dec_valid = 1; ex_new = 1; ex_lat = 4'(L);
      #1;
      chk("R6 first cycle dec_stall", dec_stall, (L > 1));
      chk("R6 first cycle fe_stall", fe_stall, (L > 1));
      chk("R3 no bubble in exec stall", bubble, 0);
      tick();
      for (int k = 1; k <= L; k++) begin
        dec_valid = 1;
        #1 chk("R6 later cycle dec_stall", dec_stall, (k < L - 1));
        tick();
      end
    end

    // R7 R8 R10: plain branch
    dec_valid = 1; ctrl = 1;
    #1;
    chk("R7 fetch held by branch in decode", fe_stall, 1);
    chk("R7 decode not held by branch", dec_stall, 0);
    chk("R8 no redirect before resolve", redirect, 0);
    tick(); exp_ch++;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R7 fetch frozen while pending", fe_stall, 1);
      tick();
    end
    resolve = 1;
    #1;
    chk("R8 redirect on resolve", redirect, 1);
    chk("R7 fetch held in resolve cycle", fe_stall, 1);
    tick();
    #1;
    chk("R7 fetch free after resolve", fe_stall, 0);
    chk("R8 redirect drops", redirect, 0);
    resolve = 1;
    #1 chk("R8 stray resolve ignored", redirect, 0);
    tick();

    // R10 R9: branch held by a data hazard
    dec_valid = 1; dst = 9; dst_vld = 1;
    tick();
    for (int k = 0; k < 2; k++) begin
      dec_valid = 1; ctrl = 1; sa = 9; sa_vld = 1;
      #1 chk("R2 branch waits on source", dec_stall, 1);
      tick(); exp_ch++; exp_dh++;
    end
    dec_valid = 1; ctrl = 1; sa = 9; sa_vld = 1; wb_valid = 1; wb_dst = 9; wb_dst_vld = 1;
    #1 chk("R4 branch released", dec_stall, 0);
    tick(); exp_ch++; exp_ret++;
    resolve = 1;
    #1 chk("R8 redirect after held branch", redirect, 1);
    tick();
    #1;
    chk("R10 control hazard count", ch_cnt, 32'(exp_ch));
    chk("R9 data hazard count", dh_cnt, 32'(exp_dh));
    chk("R11 retired count", ret_cnt, 32'(exp_ret));

    // R12: watchdog
    dec_valid = 1;
    tick();
    repeat (999) tick();
    #1 chk("R12 no timeout at 999 idle edges", timeout, 0);
    tick();
    #1;
    chk("R12 timeout at 1000 idle edges", timeout, 1);
    chk("R12 dec_stall forced", dec_stall, 1);
    chk("R12 fe_stall forced", fe_stall, 1);
    wb_valid = 1; wb_dst = 3; wb_dst_vld = 1;
    tick();
    #1;
    chk("R12 counters frozen", ret_cnt, 32'(exp_ret));
    chk("R12 timeout sticky", timeout, 1);

    done = 1;
    finish_run();
  end
endmodule